// File: doc/BRIEF.md
# Thermal Sensor Auto-Compare Shutdown Controller

This block sets the pace for temperature conversions on up to four sensor channels of an external ADC. Two are typical. While automatic mode is on, it requests one conversion per channel in ascending channel order. It stores each result, cut to the configured data width, and then waits a programmable gap before the next round. There are two gap lengths. The short gap is used while any channel is hot, and the long gap is used otherwise.

Each result is checked against two per-channel thresholds, one for alarm and one for shutdown. A crossing counts only after it has been seen on a programmable number of consecutive samples.

- **Debounced alarm:** sets a sticky pending bit, which can raise the interrupt.
- **Debounced shutdown:** latches until reset. Each channel's latch can drive a request to the reset unit, or an external pin whose active level is programmable.

Software reaches the configuration and results through a simple register port. Writes take effect at the clock edge, and reads are combinational.

Top module: `thermsense_ctrl`

## Requirements
- R1: After reset, the debounce registers (offsets 0x60 and 0x64) read 4. The normal gap (0x68) reads 250 and the hot gap (0x6C) reads 50. Pending (0x0C) reads 0. `alarm_irq` and `shut_rst_req` are 0. Because polarity resets to active-low, `shut_pin` is 1.
- R2: The register fields read back as written:
  - Auto control (0x04): bit 0 enable, bit 1 quality select, bit 4+n shutdown compare enable for channel n, bit 8 pin polarity.
  - Interrupt enable (0x08): bit n alarm interrupt, bit 4+n pin route, bit 8+n reset route.
  - Thresholds: alarm at 0x30+4n, shutdown at 0x40+4n.
  - Channel data (0x20+4n) is read-only, and writes to it are ignored.
- R3: While enabled, the block converts channels 0 to NCH-1 in order. Each conversion is one `adc_start` pulse with `adc_chan`, followed by waiting for `adc_done`. The result is stored as the low DATA_W bits of `adc_code`, and the upper bits of the data register read as zero.
- R4: With an increasing characteristic (DECREASING=0), a sample crosses a threshold when code >= threshold. A code one below the threshold is not a crossing. With DECREASING=1, the test is code <= threshold.
- R5: Alarm pending bit n (0x0C bit n) is set on the Nth consecutive alarm crossing of channel n, where N is the alarm debounce count and 0 is treated as 1. A non-crossing sample clears the count and the channel's hot state.
- R6: `alarm_irq` is high while any pending alarm bit has its enable bit set. Writing 1 to a pending bit clears it.
- R7: After the last channel's result, the gap before the next round is the hot gap while any channel is hot, and the normal gap otherwise. The gap is counted in clock cycles, with a minimum of 1.
- R8: When shutdown compare is enabled for channel n, the Nth consecutive shutdown crossing latches that channel's shutdown until reset, where N is the shutdown debounce count. It also sets pending bit 4+n, which is write-1-to-clear. Clearing that bit does not release the latch.
- R9: `shut_rst_req` is high when any latched channel has its reset-route bit set. `shut_pin` is active when any latched channel has its pin-route bit set; active means high if auto-control bit 8 is 1 and low otherwise.
- R10: With HAS_QSEL=1, auto-control bit 1 is readable and writable and drives `adc_qsel`. With HAS_QSEL=0, the bit reads 0.
- R11: Clearing the enable bit stops new rounds. No `adc_start` follows once the current round and gap have ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | CH_W | Channel being converted |
| adc_qsel | output | 1 | Quality-select level to ADC |
| adc_done | input | 1 | Conversion result valid |
| adc_code | input | ADC_W | Raw ADC code |
| alarm_irq | output | 1 | Alarm interrupt |
| shut_rst_req | output | 1 | Shutdown request to reset unit |
| shut_pin | output | 1 | Shutdown pin, programmable polarity |

## Verification
A result is captured on the edge where `adc_done` is seen. The channel state and shutdown latch change on the following edge, and the alarm pending bit one edge after that. So the bench waits three edges after the last channel's `adc_done` before it samples the registers and outputs, on a falling edge.

The bench's ADC answers two cycles after each request. A round therefore takes two cycles per channel plus the selected gap, which gives 4 plus the gap between channel-0 requests for two channels. The period checks compare measured spacing against that figure.

Vectors hold codes steady for whole rounds, so the debounce counts move by exactly one per round.

// File: rtl/thermsense_pkg.sv
package thermsense_pkg;
   localparam logic [7:0] A_USER  = 8'h00;
   localparam logic [7:0] A_AUTO  = 8'h04;
   localparam logic [7:0] A_IEN   = 8'h08;
   localparam logic [7:0] A_PEND  = 8'h0C;
   localparam logic [7:0] A_DATA0 = 8'h20;
   localparam logic [7:0] A_ATHR0 = 8'h30;
   localparam logic [7:0] A_STHR0 = 8'h40;
   localparam logic [7:0] A_ADEB  = 8'h60;
   localparam logic [7:0] A_SDEB  = 8'h64;
   localparam logic [7:0] A_PNORM = 8'h68;
   localparam logic [7:0] A_PHOT  = 8'h6C;

   localparam int B_EN      = 0;
   localparam int B_QSEL    = 1;
   localparam int B_SEN     = 4;
   localparam int B_POL     = 8;
   localparam int B_PIN     = 4;
   localparam int B_RST     = 8;
   localparam int B_PSHUT   = 4;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2,
      SQ_GAP  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/thermsense_debounce.sv
module thermsense_debounce #(
   parameter int DEB_W  = 8,
   parameter bit STICKY = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic             hit,
   input  logic             arm,
   input  logic [DEB_W-1:0] limit,
   output logic             active,
   output logic             rise
);
   logic [DEB_W-1:0] cnt;
   logic [DEB_W:0]   lim_eff;
   logic [DEB_W:0]   cnt_nxt;

   assign lim_eff = (limit == '0) ? (DEB_W+1)'(1) : {1'b0, limit};
   assign cnt_nxt = {1'b0, cnt} + (DEB_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
         rise   <= 1'b0;
      end else begin
         rise <= 1'b0;
         if (vld) begin
            if (arm && hit) begin
               if (!active) begin
                  if (cnt_nxt >= lim_eff) begin
                     active <= 1'b1;
                     rise   <= 1'b1;
                     cnt    <= '0;
                  end else begin
                     cnt <= cnt_nxt[DEB_W-1:0];
                  end
               end
            end else begin
               cnt <= '0;
               if (!STICKY) active <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/thermsense_chan.sv
module thermsense_chan #(
   parameter int DATA_W     = 10,
   parameter int DEB_W      = 8,
   parameter bit DECREASING = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [DATA_W-1:0] smp_code,
   input  logic [DATA_W-1:0] alarm_thr,
   input  logic [DATA_W-1:0] shut_thr,
   input  logic [DEB_W-1:0]  alarm_deb,
   input  logic [DEB_W-1:0]  shut_deb,
   input  logic              shut_en,
   output logic [DATA_W-1:0] data,
   output logic              hot,
   output logic              alarm_evt,
   output logic              shut_lat,
   output logic              shut_evt
);
   logic a_cross;
   logic s_cross;

   generate
      if (DECREASING) begin : g_dec
         assign a_cross = (smp_code <= alarm_thr);
         assign s_cross = (smp_code <= shut_thr);
      end else begin : g_inc
         assign a_cross = (smp_code >= alarm_thr);
         assign s_cross = (smp_code >= shut_thr);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data <= '0;
      else if (smp_vld) data <= smp_code;
   end

   thermsense_debounce #(.DEB_W(DEB_W), .STICKY(1'b0)) u_alarm (
      .clk(clk), .rst_n(rst_n), .vld(smp_vld), .hit(a_cross), .arm(1'b1),
      .limit(alarm_deb), .active(hot), .rise(alarm_evt)
   );

   thermsense_debounce #(.DEB_W(DEB_W), .STICKY(1'b1)) u_shut (
      .clk(clk), .rst_n(rst_n), .vld(smp_vld), .hit(s_cross), .arm(shut_en),
      .limit(shut_deb), .active(shut_lat), .rise(shut_evt)
   );
endmodule

// File: rtl/thermsense_seq.sv
module thermsense_seq
   import thermsense_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int ADC_W  = 12,
   parameter int DATA_W = 10,
   parameter int PER_W  = 16,
   parameter int CH_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              auto_en,
   input  logic              any_hot,
   input  logic [PER_W-1:0]  per_norm,
   input  logic [PER_W-1:0]  per_hot,
   input  logic              adc_done,
   input  logic [ADC_W-1:0]  adc_code,
   output logic              adc_start,
   output logic [CH_W-1:0]   adc_chan,
   output logic              smp_vld,
   output logic [CH_W-1:0]   smp_ch,
   output logic [DATA_W-1:0] smp_code
);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH-1);

   seq_state_e       state;
   logic [CH_W-1:0]  ch;
   logic [PER_W-1:0] gap_cnt;
   logic [PER_W-1:0] per_sel;
   logic             gap_end;

   assign per_sel   = any_hot ? per_hot : per_norm;
   assign gap_end   = ({1'b0, gap_cnt} + (PER_W+1)'(1)) >= {1'b0, per_sel};
   assign adc_start = (state == SQ_REQ);
   assign adc_chan  = ch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         ch       <= '0;
         gap_cnt  <= '0;
         smp_vld  <= 1'b0;
         smp_ch   <= '0;
         smp_code <= '0;
      end else begin
         smp_vld <= 1'b0;
         unique case (state)
            SQ_IDLE: if (auto_en) begin
               ch    <= '0;
               state <= SQ_REQ;
            end
            SQ_REQ: state <= SQ_WAIT;
            SQ_WAIT: if (adc_done) begin
               smp_vld  <= 1'b1;
               smp_ch   <= ch;
               smp_code <= adc_code[DATA_W-1:0];
               if (ch == LAST_CH) begin
                  gap_cnt <= '0;
                  state   <= SQ_GAP;
               end else begin
                  ch    <= ch + CH_W'(1);
                  state <= SQ_REQ;
               end
            end
            SQ_GAP: begin
               if (!auto_en) begin
                  state <= SQ_IDLE;
               end else if (gap_end) begin
                  ch    <= '0;
                  state <= SQ_REQ;
               end else begin
                  gap_cnt <= gap_cnt + PER_W'(1);
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/thermsense_regs.sv
module thermsense_regs
   import thermsense_pkg::*;
#(
   parameter int NCH          = 2,
   parameter int DATA_W       = 10,
   parameter int DEB_W        = 8,
   parameter int PER_W        = 16,
   parameter bit HAS_QSEL     = 1'b1,
   parameter int DEF_ADEB     = 4,
   parameter int DEF_SDEB     = 4,
   parameter int DEF_PER_NORM = 250,
   parameter int DEF_PER_HOT  = 50
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [7:0]                   reg_addr,
   input  logic                         reg_wr,
   input  logic [31:0]                  reg_wdata,
   output logic [31:0]                  reg_rdata,
   input  logic [NCH-1:0]               alarm_evt,
   input  logic [NCH-1:0]               shut_evt,
   input  logic [NCH-1:0][DATA_W-1:0]   chan_data,
   output logic                         auto_en,
   output logic                         qsel,
   output logic                         pol_high,
   output logic [NCH-1:0]               shut_en,
   output logic [NCH-1:0]               irq_en,
   output logic [NCH-1:0]               route_pin,
   output logic [NCH-1:0]               route_rst,
   output logic [NCH-1:0]               pend_alarm,
   output logic [NCH-1:0][DATA_W-1:0]   alarm_thr,
   output logic [NCH-1:0][DATA_W-1:0]   shut_thr,
   output logic [DEB_W-1:0]             alarm_deb,
   output logic [DEB_W-1:0]             shut_deb,
   output logic [PER_W-1:0]             per_norm,
   output logic [PER_W-1:0]             per_hot
);
   logic [15:0]    user_q;
   logic [NCH-1:0] pend_shut;
   logic           wr_auto;
   logic           wr_pend;

   assign wr_auto = reg_wr && (reg_addr == A_AUTO);
   assign wr_pend = reg_wr && (reg_addr == A_PEND);

   generate
      if (HAS_QSEL) begin : g_qsel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       qsel <= 1'b0;
            else if (wr_auto) qsel <= reg_wdata[B_QSEL];
         end
      end else begin : g_noqsel
         assign qsel = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         user_q    <= '0;
         auto_en   <= 1'b0;
         pol_high  <= 1'b0;
         shut_en   <= '0;
         irq_en    <= '0;
         route_pin <= '0;
         route_rst <= '0;
         alarm_thr <= '1;
         shut_thr  <= '1;
         alarm_deb <= DEB_W'(DEF_ADEB);
         shut_deb  <= DEB_W'(DEF_SDEB);
         per_norm  <= PER_W'(DEF_PER_NORM);
         per_hot   <= PER_W'(DEF_PER_HOT);
      end else if (reg_wr) begin
         case (reg_addr)
            A_USER: user_q <= reg_wdata[15:0];
            A_AUTO: begin
               auto_en  <= reg_wdata[B_EN];
               pol_high <= reg_wdata[B_POL];
               shut_en  <= reg_wdata[B_SEN +: NCH];
            end
            A_IEN: begin
               irq_en    <= reg_wdata[0 +: NCH];
               route_pin <= reg_wdata[B_PIN +: NCH];
               route_rst <= reg_wdata[B_RST +: NCH];
            end
            A_ADEB:  alarm_deb <= reg_wdata[DEB_W-1:0];
            A_SDEB:  shut_deb  <= reg_wdata[DEB_W-1:0];
            A_PNORM: per_norm  <= reg_wdata[PER_W-1:0];
            A_PHOT:  per_hot   <= reg_wdata[PER_W-1:0];
            default: ;
         endcase
         for (int n = 0; n < NCH; n++) begin
            if (reg_addr == A_ATHR0 + 8'(4*n)) alarm_thr[n] <= reg_wdata[DATA_W-1:0];
            if (reg_addr == A_STHR0 + 8'(4*n)) shut_thr[n]  <= reg_wdata[DATA_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_alarm <= '0;
         pend_shut  <= '0;
      end else begin
         for (int n = 0; n < NCH; n++) begin
            pend_alarm[n] <= alarm_evt[n] |
                             (pend_alarm[n] & ~(wr_pend & reg_wdata[n]));
            pend_shut[n]  <= shut_evt[n] |
                             (pend_shut[n] & ~(wr_pend & reg_wdata[B_PSHUT+n]));
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_USER: reg_rdata[15:0] = user_q;
         A_AUTO: begin
            reg_rdata[B_EN]         = auto_en;
            reg_rdata[B_QSEL]       = qsel;
            reg_rdata[B_SEN +: NCH] = shut_en;
            reg_rdata[B_POL]        = pol_high;
         end
         A_IEN: begin
            reg_rdata[0 +: NCH]     = irq_en;
            reg_rdata[B_PIN +: NCH] = route_pin;
            reg_rdata[B_RST +: NCH] = route_rst;
         end
         A_PEND: begin
            reg_rdata[0 +: NCH]       = pend_alarm;
            reg_rdata[B_PSHUT +: NCH] = pend_shut;
         end
         A_ADEB:  reg_rdata[DEB_W-1:0] = alarm_deb;
         A_SDEB:  reg_rdata[DEB_W-1:0] = shut_deb;
         A_PNORM: reg_rdata[PER_W-1:0] = per_norm;
         A_PHOT:  reg_rdata[PER_W-1:0] = per_hot;
         default: ;
      endcase
      for (int n = 0; n < NCH; n++) begin
         if (reg_addr == A_DATA0 + 8'(4*n)) reg_rdata[DATA_W-1:0] = chan_data[n];
         if (reg_addr == A_ATHR0 + 8'(4*n)) reg_rdata[DATA_W-1:0] = alarm_thr[n];
         if (reg_addr == A_STHR0 + 8'(4*n)) reg_rdata[DATA_W-1:0] = shut_thr[n];
      end
   end
endmodule

// File: rtl/thermsense_ctrl.sv
module thermsense_ctrl #(
   parameter int NCH          = 2,
   parameter int ADC_W        = 12,
   parameter int DATA_W       = 10,
   parameter int DEB_W        = 8,
   parameter int PER_W        = 16,
   parameter bit DECREASING   = 1'b0,
   parameter bit HAS_QSEL     = 1'b1,
   parameter int DEF_ADEB     = 4,
   parameter int DEF_SDEB     = 4,
   parameter int DEF_PER_NORM = 250,
   parameter int DEF_PER_HOT  = 50,
   localparam int CH_W        = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              adc_start,
   output logic [CH_W-1:0]   adc_chan,
   output logic              adc_qsel,
   input  logic              adc_done,
   input  logic [ADC_W-1:0]  adc_code,
   output logic              alarm_irq,
   output logic              shut_rst_req,
   output logic              shut_pin
);
   generate
      if (NCH < 1 || NCH > 4) begin : g_bad_nch
         $error("thermsense_ctrl: NCH must be 1..4");
      end
      if (DATA_W > ADC_W || DATA_W > 16) begin : g_bad_dw
         $error("thermsense_ctrl: DATA_W must not exceed ADC_W or 16");
      end
      if (PER_W > 32 || DEB_W > 32) begin : g_bad_w
         $error("thermsense_ctrl: counter widths limited to 32");
      end
   endgenerate

   logic                       auto_en, qsel, pol_high;
   logic [NCH-1:0]             shut_en, irq_en, route_pin, route_rst, pend_alarm;
   logic [NCH-1:0][DATA_W-1:0] alarm_thr, shut_thr, chan_data;
   logic [DEB_W-1:0]           alarm_deb, shut_deb;
   logic [PER_W-1:0]           per_norm, per_hot;
   logic [NCH-1:0]             chan_hot, alarm_evt, shut_lat, shut_evt;
   logic                       smp_vld;
   logic [CH_W-1:0]            smp_ch;
   logic [DATA_W-1:0]          smp_code;
   logic                       pin_hit;

   thermsense_regs #(
      .NCH(NCH), .DATA_W(DATA_W), .DEB_W(DEB_W), .PER_W(PER_W),
      .HAS_QSEL(HAS_QSEL), .DEF_ADEB(DEF_ADEB), .DEF_SDEB(DEF_SDEB),
      .DEF_PER_NORM(DEF_PER_NORM), .DEF_PER_HOT(DEF_PER_HOT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_evt(alarm_evt),
      .shut_evt(shut_evt), .chan_data(chan_data), .auto_en(auto_en),
      .qsel(qsel), .pol_high(pol_high), .shut_en(shut_en), .irq_en(irq_en),
      .route_pin(route_pin), .route_rst(route_rst), .pend_alarm(pend_alarm),
      .alarm_thr(alarm_thr), .shut_thr(shut_thr), .alarm_deb(alarm_deb),
      .shut_deb(shut_deb), .per_norm(per_norm), .per_hot(per_hot)
   );

   thermsense_seq #(
      .NCH(NCH), .ADC_W(ADC_W), .DATA_W(DATA_W), .PER_W(PER_W), .CH_W(CH_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .any_hot(|chan_hot),
      .per_norm(per_norm), .per_hot(per_hot), .adc_done(adc_done),
      .adc_code(adc_code), .adc_start(adc_start), .adc_chan(adc_chan),
      .smp_vld(smp_vld), .smp_ch(smp_ch), .smp_code(smp_code)
   );

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_ch
         thermsense_chan #(
            .DATA_W(DATA_W), .DEB_W(DEB_W), .DECREASING(DECREASING)
         ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .smp_vld(smp_vld && (smp_ch == CH_W'(n))),
            .smp_code(smp_code), .alarm_thr(alarm_thr[n]),
            .shut_thr(shut_thr[n]), .alarm_deb(alarm_deb),
            .shut_deb(shut_deb), .shut_en(shut_en[n]),
            .data(chan_data[n]), .hot(chan_hot[n]),
            .alarm_evt(alarm_evt[n]), .shut_lat(shut_lat[n]),
            .shut_evt(shut_evt[n])
         );
      end
   endgenerate

   assign adc_qsel     = qsel;
   assign alarm_irq    = |(pend_alarm & irq_en);
   assign shut_rst_req = |(shut_lat & route_rst);
   assign pin_hit      = |(shut_lat & route_pin);
   assign shut_pin     = pol_high ? pin_hit : ~pin_hit;
endmodule

// File: rtl/thermsense_chk.sv
module thermsense_chk #(
   parameter int NCH    = 2,
   parameter int DATA_W = 10
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       adc_start,
   input logic                       smp_vld,
   input logic [NCH-1:0]             hot,
   input logic [NCH-1:0]             shut_lat,
   input logic [NCH-1:0]             pend,
   input logic [NCH-1:0][DATA_W-1:0] data
);
   // R3
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);

   // R8
   shut_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(shut_lat) & ~shut_lat) == '0));

   // R5
   hot_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|hot) |-> $past(smp_vld));

   // R5
   pend_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|pend) |-> $past(smp_vld, 2));

   // R3
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_vld) |-> $stable(data));
endmodule

bind thermsense_ctrl thermsense_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .smp_vld(smp_vld),
   .hot(chan_hot), .shut_lat(shut_lat), .pend(pend_alarm), .data(chan_data)
);

// File: tb/thermsense_ctrl_tb.sv
module thermsense_ctrl_tb;
   localparam int CLK_NS = 10;

   typedef struct packed {
      logic [11:0] c0;
      logic [11:0] c1;
      logic [3:0]  rounds;
      logic [7:0]  clr;
      logic [7:0]  pend;
      logic        irq;
      logic        rst;
      logic        pin;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{12'd100,  12'd100, 4'd2, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
      '{12'd500,  12'd100, 4'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
      '{12'd100,  12'd100, 4'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
      '{12'd500,  12'd100, 4'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
      '{12'hDF4,  12'd100, 4'd1, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0},
      '{12'd499,  12'd100, 4'd2, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0},
      '{12'd700,  12'd100, 4'd2, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0},
      '{12'd700,  12'd100, 4'd1, 8'h00, 8'h11, 1'b1, 1'b0, 1'b1},
      '{12'd100,  12'd100, 4'd1, 8'h11, 8'h00, 1'b0, 1'b0, 1'b1},
      '{12'd100,  12'd800, 4'd3, 8'h00, 8'h22, 1'b1, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        adc_start;
   logic [0:0]  adc_chan;
   logic        adc_qsel;
   logic        adc_done = 1'b0;
   logic [11:0] adc_code = '0;
   logic        alarm_irq, shut_rst_req, shut_pin;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int done1 = 0;
   int s0cnt = 0;
   int t0_prev = 0;
   int t0_last = 0;
   int starts = 0;
   logic [11:0] codes [2];
   bit pend_resp = 1'b0;
   logic [0:0] resp_ch = '0;

   thermsense_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_start(adc_start),
      .adc_chan(adc_chan), .adc_qsel(adc_qsel), .adc_done(adc_done),
      .adc_code(adc_code), .alarm_irq(alarm_irq),
      .shut_rst_req(shut_rst_req), .shut_pin(shut_pin)
   );

   initial forever #(CLK_NS/2) clk = ~clk;
   initial forever begin @(posedge clk); cyc++; end

   // ADC model: answers two cycles after each request
   initial begin
      codes[0] = 12'd100;
      codes[1] = 12'd100;
      forever begin
         @(negedge clk);
         adc_done = 1'b0;
         if (pend_resp) begin
            adc_done  = 1'b1;
            adc_code  = codes[resp_ch];
            pend_resp = 1'b0;
            if (resp_ch == 1'b1) done1++;
         end
         if (adc_start) begin
            pend_resp = 1'b1;
            resp_ch   = adc_chan;
            starts++;
            if (adc_chan == 1'b0) begin
               t0_prev = t0_last;
               t0_last = cyc;
               s0cnt++;
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic run_rounds(input int k);
      int target;
      target = done1 + k;
      wait (done1 >= target);
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic measure(output int d);
      int base;
      base = s0cnt;
      wait (s0cnt >= base + 2);
      d = t0_last - t0_prev;
   endtask

   initial begin
      #(CLK_NS * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h60, v); chk("R1 alarm debounce", v, 32'd4);
      rd(8'h64, v); chk("R1 shut debounce", v, 32'd4);
      rd(8'h68, v); chk("R1 normal gap", v, 32'd250);
      rd(8'h6C, v); chk("R1 hot gap", v, 32'd50);
      rd(8'h0C, v); chk("R1 pending", v, 32'd0);
      chk("R1 irq", {31'd0, alarm_irq}, 32'd0);
      chk("R1 rst req", {31'd0, shut_rst_req}, 32'd0);
      chk("R1 pin idle high", {31'd0, shut_pin}, 32'd1);

      // R10 quality select
      wr(8'h04, 32'h002);
      rd(8'h04, v); chk("R10 qsel readback", v, 32'h002);
      chk("R10 qsel pin", {31'd0, adc_qsel}, 32'd1);

      // configuration
      wr(8'h60, 32'd2);
      wr(8'h64, 32'd3);
      wr(8'h68, 32'd10);
      wr(8'h6C, 32'd4);
      wr(8'h30, 32'd500);
      wr(8'h34, 32'd600);
      wr(8'h40, 32'd700);
      wr(8'h44, 32'd800);
      wr(8'h08, 32'h213);
      rd(8'h08, v); chk("R2 int enable readback", v, 32'h213);
      rd(8'h34, v); chk("R2 alarm thr ch1", v, 32'd600);
      wr(8'h04, 32'h131);
      rd(8'h04, v); chk("R2 auto control readback", v, 32'h131);

      // vector walk: R3 R4 R5 R6 R8 R9
      for (int i = 0; i < NV; i++) begin
         codes[0] = VECS[i].c0;
         codes[1] = VECS[i].c1;
         if (VECS[i].clr != 8'h00) wr(8'h0C, {24'd0, VECS[i].clr});
         run_rounds(int'(VECS[i].rounds));
         rd(8'h0C, v);
         chk($sformatf("vec %0d pending R5 R8", i), v, {24'd0, VECS[i].pend});
         chk($sformatf("vec %0d irq R6", i), {31'd0, alarm_irq}, {31'd0, VECS[i].irq});
         chk($sformatf("vec %0d rst req R9", i), {31'd0, shut_rst_req}, {31'd0, VECS[i].rst});
         chk($sformatf("vec %0d pin R9", i), {31'd0, shut_pin}, {31'd0, VECS[i].pin});
         if (i == 4) begin
            rd(8'h20, v); chk("R3 masked data ch0", v, 32'd500);
         end
      end

      // R7 hot gap (ch1 hot) then normal gap
      measure(d); chk("R7 hot round spacing", d, 32'd8);
      codes[1] = 12'd100;
      run_rounds(2);
      measure(d); chk("R7 normal round spacing", d, 32'd14);

      // R2 data register read-only
      rd(8'h24, v); chk("R2 data ch1", v, 32'd100);
      wr(8'h20, 32'h155);
      rd(8'h20, v); chk("R2 data write ignored", v, 32'd100);

      // R11 disable
      wr(8'h04, 32'h130);
      repeat (20) @(negedge clk);
      begin
         int s;
         s = starts;
         repeat (30) @(negedge clk);
         chk("R11 no starts after disable", starts - s, 32'd0);
      end
      chk("R8 latch held after disable", {31'd0, shut_rst_req}, 32'd1);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule